// File: doc/BRIEF.md
# Indirect Register Window Bridge

This block sits as a slave on a 64-bit host register bus. Through a small command window it gives software access to a 32-bit register space behind it. Software first loads a staging register with the value it wants to write. It then writes a command word that holds a downstream word address (the byte address divided by four) and one request bit, either write or read. The bridge latches the command and drives exactly one transaction on a single-outstanding memory-mapped master port. It keeps the request bit set until that transaction is finished, so software polls the same bit to learn when the access has completed. For a read, the returned 32-bit word appears in a result register, and bit 32 of that register is a debug flag.

A downstream side that never answers does not hang the bridge. After a parameterised number of cycles it drops the transaction, clears the request bit and raises the debug flag. A read-only descriptor register, built from parameters, reports how the attached serial controller is configured: bit order, word width, select count, clock polarity and phase, clock setting and an identifier.

Top module: `regwin_bridge`

## Requirements
- R1: While reset is asserted and after it is released, the command register (0x10), the result register (0x18) and the staging register (0x20) read zero, and neither dn_read nor dn_write is asserted.
- R2: Offset 0x08 reads the descriptor: bit 1 is bit order (1 = LSB first), bits 7:2 word width, bits 13:8 select count, bit 14 clock polarity, bit 15 clock phase, bits 31:22 clock setting, bits 47:32 identifier, and every other bit is zero.
- R3: A command write to 0x10 with bit 8 set (bit 9 clear) issues one downstream write. The write uses address bits [DN_AW-1:0] of the command and the value staged beforehand at 0x20, which reads back in bits 31:0 of 0x20.
- R4: A command write to 0x10 with bit 9 set (bit 8 clear) issues one downstream read. The word returned with dn_rvalid appears in bits 31:0 of 0x18 once the request bit has cleared.
- R5: The command register reads back the latched address in its low bits, with bit 8 or bit 9 set while the transaction is outstanding. The bit clears by itself in the cycle after the transaction finishes.
- R6: While dn_stall is high, the bridge holds dn_read or dn_write asserted and keeps dn_addr and dn_wdata stable.
- R7: A command written while a request bit is set is ignored. The latched address, the request bits and the downstream traffic are unchanged.
- R8: A command with both bit 8 and bit 9 set is ignored. It starts no transaction and leaves the command register unchanged.
- R9: If a transaction has not finished TIMEOUT_CYC cycles after its command, the bridge aborts it. It clears the request bit and sets bit 32 of 0x18, and the next accepted command clears that flag again.
- R10: Reads of unmapped offsets return zero. Writes to 0x08, to 0x18 or to unmapped offsets change no register and start no transaction.
- R11: dn_read and dn_write are never asserted together, and no new transaction starts while one is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | HOST_AW | Host byte offset |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 64 | Host write value |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 64 | Host read value, valid in the same cycle as host_rd |
| dn_addr | output | DN_AW | Downstream word address |
| dn_read | output | 1 | Downstream read request |
| dn_write | output | 1 | Downstream write request |
| dn_wdata | output | 32 | Downstream write value |
| dn_rdata | input | 32 | Downstream read value |
| dn_rvalid | input | 1 | Downstream read value strobe |
| dn_stall | input | 1 | Downstream stall; request is held while high |

## Verification
The bench stalls requests for several cycles and checks, mid-stall, that the request and its address are still held. A bridge that let go early would lose or duplicate a downstream access, and the scoreboard would flag it. Commands sent while the bridge is busy, and commands with both request bits set, must produce no traffic at all: a design that accepted them would push an unexpected item at the scoreboard or overwrite the latched address. A downstream side that never answers must be aborted within a narrow window of cycles with the debug flag raised. A design without the timeout would hang, and one that cleared the flag wrongly would show a stale bit 32 on the next successful read.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

   localparam int HOST_DW = 64;
   localparam int DN_DW   = 32;

   // host byte offsets of the visible registers
   localparam logic [7:0] OFS_DESC  = 8'h08;
   localparam logic [7:0] OFS_CMD   = 8'h10;
   localparam logic [7:0] OFS_RES   = 8'h18;
   localparam logic [7:0] OFS_STAGE = 8'h20;

   // command word bit positions
   localparam int CMD_WR_BIT = 8;
   localparam int CMD_RD_BIT = 9;
   localparam int DBG_BIT    = 32;

   typedef enum logic [1:0] {
      MST_IDLE  = 2'd0,
      MST_ISSUE = 2'd1,
      MST_WAIT  = 2'd2
   } mst_state_t;

endpackage

// File: rtl/regwin_desc_reg.sv
module regwin_desc_reg #(
   parameter int LSB_FIRST = 0,
   parameter int XFER_W    = 32,
   parameter int CS_COUNT  = 1,
   parameter int CPOL      = 0,
   parameter int CPHA      = 0,
   parameter int SCLK_SEL  = 12,
   parameter int DEV_ID    = 16'h5A3C
) (
   output logic [63:0] word_o
);

   if (XFER_W < 1 || XFER_W > 63) begin : g_bad_xfer
      $error("regwin_desc_reg: XFER_W out of range");
   end
   if (CS_COUNT < 0 || CS_COUNT > 63) begin : g_bad_cs
      $error("regwin_desc_reg: CS_COUNT out of range");
   end
   if (SCLK_SEL < 0 || SCLK_SEL > 1023) begin : g_bad_sclk
      $error("regwin_desc_reg: SCLK_SEL out of range");
   end
   if (DEV_ID < 0 || DEV_ID > 65535) begin : g_bad_id
      $error("regwin_desc_reg: DEV_ID out of range");
   end

   always_comb begin
      word_o        = '0;
      word_o[1]     = (LSB_FIRST != 0);
      word_o[7:2]   = 6'(XFER_W);
      word_o[13:8]  = 6'(CS_COUNT);
      word_o[14]    = (CPOL != 0);
      word_o[15]    = (CPHA != 0);
      word_o[31:22] = 10'(SCLK_SEL);
      word_o[47:32] = 16'(DEV_ID);
   end

endmodule

// File: rtl/regwin_dn_master.sv
module regwin_dn_master
   import regwin_pkg::*;
#(
   parameter int AW          = 8,
   parameter int DW          = 32,
   parameter int TIMEOUT_CYC = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_wr,
   input  logic          start_rd,
   input  logic [AW-1:0] start_addr,
   input  logic [DW-1:0] start_wdata,
   output logic [AW-1:0] dn_addr,
   output logic          dn_read,
   output logic          dn_write,
   output logic [DW-1:0] dn_wdata,
   input  logic [DW-1:0] dn_rdata,
   input  logic          dn_rvalid,
   input  logic          dn_stall,
   output logic          done_o,
   output logic          abort_o,
   output logic [DW-1:0] rdata_o
);

   if (TIMEOUT_CYC < 0) begin : g_bad_to
      $error("regwin_dn_master: TIMEOUT_CYC must not be negative");
   end

   mst_state_t    st_q;
   logic          op_rd_q;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] wdata_q;
   logic          timer_hit;

   assign dn_addr  = addr_q;
   assign dn_wdata = wdata_q;
   assign dn_read  = (st_q == MST_ISSUE) &&  op_rd_q;
   assign dn_write = (st_q == MST_ISSUE) && !op_rd_q;
   assign rdata_o  = dn_rdata;

   // completion wins over a timeout that lands in the same cycle
   assign done_o  = ((st_q == MST_ISSUE) && !dn_stall && !op_rd_q) ||
                    ((st_q == MST_WAIT) && dn_rvalid);
   assign abort_o = timer_hit && !done_o && (st_q != MST_IDLE);

   if (TIMEOUT_CYC > 0) begin : g_timer
      localparam int CW = $clog2(TIMEOUT_CYC + 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
         if (!rst_n)               cnt_q <= '0;
         else if (st_q == MST_IDLE) cnt_q <= '0;
         else                      cnt_q <= cnt_q + 1'b1;
      end
      assign timer_hit = (cnt_q == CW'(TIMEOUT_CYC - 1));
   end else begin : g_no_timer
      assign timer_hit = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= MST_IDLE;
         op_rd_q <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else begin
         case (st_q)
            MST_IDLE: begin
               if (start_wr || start_rd) begin
                  st_q    <= MST_ISSUE;
                  op_rd_q <= start_rd;
                  addr_q  <= start_addr;
                  wdata_q <= start_wdata;
               end
            end
            MST_ISSUE: begin
               if (!dn_stall)    st_q <= op_rd_q ? MST_WAIT : MST_IDLE;
               else if (abort_o) st_q <= MST_IDLE;
            end
            MST_WAIT: begin
               if (dn_rvalid || abort_o) st_q <= MST_IDLE;
            end
            default: st_q <= MST_IDLE;
         endcase
      end
   end

   // R6
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == MST_ISSUE && dn_stall && !abort_o) |=>
      (st_q == MST_ISSUE && $stable(dn_addr) && $stable(dn_wdata) && $stable(dn_read)));

   // R11
   one_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({dn_read, dn_write}));

   // R11
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_wr || start_rd) |-> (st_q == MST_IDLE && !(start_wr && start_rd)));

endmodule

// File: rtl/regwin_bridge.sv
module regwin_bridge
   import regwin_pkg::*;
#(
   parameter int HOST_AW     = 6,
   parameter int DN_AW       = 8,
   parameter int TIMEOUT_CYC = 64,
   parameter int LSB_FIRST   = 0,
   parameter int XFER_W      = 32,
   parameter int CS_COUNT    = 1,
   parameter int CPOL        = 0,
   parameter int CPHA        = 0,
   parameter int SCLK_SEL    = 12,
   parameter int DEV_ID      = 16'h5A3C
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [HOST_AW-1:0] host_addr,
   input  logic               host_wr,
   input  logic [63:0]        host_wdata,
   input  logic               host_rd,
   output logic [63:0]        host_rdata,
   output logic [DN_AW-1:0]   dn_addr,
   output logic               dn_read,
   output logic               dn_write,
   output logic [31:0]        dn_wdata,
   input  logic [31:0]        dn_rdata,
   input  logic               dn_rvalid,
   input  logic               dn_stall
);

   if (HOST_AW < 6 || HOST_AW > 8) begin : g_bad_haw
      $error("regwin_bridge: HOST_AW must be 6..8");
   end
   if (DN_AW < 1 || DN_AW > CMD_WR_BIT) begin : g_bad_daw
      $error("regwin_bridge: DN_AW must fit below the request bits");
   end

   localparam logic [HOST_AW-1:0] A_DESC  = HOST_AW'(OFS_DESC);
   localparam logic [HOST_AW-1:0] A_CMD   = HOST_AW'(OFS_CMD);
   localparam logic [HOST_AW-1:0] A_RES   = HOST_AW'(OFS_RES);
   localparam logic [HOST_AW-1:0] A_STAGE = HOST_AW'(OFS_STAGE);

   logic             req_wr_q, req_rd_q, dbg_q;
   logic [DN_AW-1:0] cmd_addr_q;
   logic [DN_DW-1:0] stage_q, res_q;
   logic [63:0]      desc_word;
   logic             busy, cmd_hit, start_wr, start_rd;
   logic [1:0]       req_bits;
   logic             mst_done, mst_abort;
   logic [DN_DW-1:0] mst_rdata;

   assign busy     = req_wr_q || req_rd_q;
   assign cmd_hit  = host_wr && (host_addr == A_CMD);
   assign req_bits = host_wdata[CMD_RD_BIT:CMD_WR_BIT];
   assign start_wr = cmd_hit && !busy && (req_bits == 2'b01);
   assign start_rd = cmd_hit && !busy && (req_bits == 2'b10);

   regwin_desc_reg #(
      .LSB_FIRST(LSB_FIRST), .XFER_W(XFER_W), .CS_COUNT(CS_COUNT),
      .CPOL(CPOL), .CPHA(CPHA), .SCLK_SEL(SCLK_SEL), .DEV_ID(DEV_ID)
   ) u_desc (
      .word_o(desc_word)
   );

   regwin_dn_master #(
      .AW(DN_AW), .DW(DN_DW), .TIMEOUT_CYC(TIMEOUT_CYC)
   ) u_mst (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_wr   (start_wr),
      .start_rd   (start_rd),
      .start_addr (host_wdata[DN_AW-1:0]),
      .start_wdata(stage_q),
      .dn_addr    (dn_addr),
      .dn_read    (dn_read),
      .dn_write   (dn_write),
      .dn_wdata   (dn_wdata),
      .dn_rdata   (dn_rdata),
      .dn_rvalid  (dn_rvalid),
      .dn_stall   (dn_stall),
      .done_o     (mst_done),
      .abort_o    (mst_abort),
      .rdata_o    (mst_rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_wr_q   <= 1'b0;
         req_rd_q   <= 1'b0;
         dbg_q      <= 1'b0;
         cmd_addr_q <= '0;
         stage_q    <= '0;
         res_q      <= '0;
      end else begin
         if (host_wr && host_addr == A_STAGE) stage_q <= host_wdata[DN_DW-1:0];
         if (start_wr || start_rd) begin
            req_wr_q   <= start_wr;
            req_rd_q   <= start_rd;
            cmd_addr_q <= host_wdata[DN_AW-1:0];
            dbg_q      <= 1'b0;
         end else if (mst_done || mst_abort) begin
            req_wr_q <= 1'b0;
            req_rd_q <= 1'b0;
         end
         if (mst_done && req_rd_q) res_q <= mst_rdata;
         if (mst_abort)            dbg_q <= 1'b1;
      end
   end

   always_comb begin
      host_rdata = '0;
      if (host_rd) begin
         case (host_addr)
            A_DESC:  host_rdata = desc_word;
            A_CMD: begin
               host_rdata[DN_AW-1:0]  = cmd_addr_q;
               host_rdata[CMD_WR_BIT] = req_wr_q;
               host_rdata[CMD_RD_BIT] = req_rd_q;
            end
            A_RES: begin
               host_rdata[DN_DW-1:0] = res_q;
               host_rdata[DBG_BIT]   = dbg_q;
            end
            A_STAGE: host_rdata[DN_DW-1:0] = stage_q;
            default: host_rdata = '0;
         endcase
      end
   end

   // R5
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !mst_done && !mst_abort) |=> busy);

   // R5
   req_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mst_done || mst_abort) |=> !busy);

   // R8
   both_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_hit && req_bits == 2'b11 && !busy) |=> (!busy && !dn_read && !dn_write));

   // R9
   abort_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mst_abort |=> (dbg_q && !busy));

   // R7
   busy_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_hit) |=> $stable(cmd_addr_q));

endmodule

// File: tb/regwin_bridge_bench.sv
module regwin_bridge_bench;

   localparam int HOST_AW = 6;
   localparam int DN_AW   = 8;
   localparam int TO_CYC  = 40;
   localparam int P_LSB   = 1;
   localparam int P_XW    = 24;
   localparam int P_CS    = 3;
   localparam int P_CPOL  = 0;
   localparam int P_CPHA  = 1;
   localparam int P_SCLK  = 645;
   localparam int P_ID    = 16'hC0DE;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [HOST_AW-1:0] host_addr = '0;
   logic               host_wr = 1'b0;
   logic [63:0]        host_wdata = '0;
   logic               host_rd = 1'b0;
   logic [63:0]        host_rdata;
   logic [DN_AW-1:0]   dn_addr;
   logic               dn_read, dn_write;
   logic [31:0]        dn_wdata;
   logic [31:0]        dn_rdata = '0;
   logic               dn_rvalid = 1'b0;
   logic               dn_stall;

   int n_tests = 0;
   int n_fail  = 0;

   always #2.5 clk = ~clk;

   regwin_bridge #(
      .HOST_AW(HOST_AW), .DN_AW(DN_AW), .TIMEOUT_CYC(TO_CYC),
      .LSB_FIRST(P_LSB), .XFER_W(P_XW), .CS_COUNT(P_CS), .CPOL(P_CPOL),
      .CPHA(P_CPHA), .SCLK_SEL(P_SCLK), .DEV_ID(P_ID)
   ) u_regwin_bridge (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
      .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
      .dn_addr(dn_addr), .dn_read(dn_read), .dn_write(dn_write),
      .dn_wdata(dn_wdata), .dn_rdata(dn_rdata), .dn_rvalid(dn_rvalid),
      .dn_stall(dn_stall)
   );

   // ---------------- downstream slave model ----------------
   int          stall_len = 0;
   int          rd_lat    = 1;
   logic        hang      = 1'b0;
   int          stall_cnt = 0;
   int          lat_cnt   = 0;
   logic        rd_pend   = 1'b0;
   logic [7:0]  rd_addr   = '0;
   logic [31:0] mem [256];

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 32'hA500_0000 | 32'(i);
   end

   assign dn_stall = hang || ((dn_read || dn_write) && (stall_cnt < stall_len));

   always @(posedge clk) begin
      dn_rvalid <= 1'b0;
      if ((dn_read || dn_write) && dn_stall) begin
         stall_cnt <= stall_cnt + 1;
      end else if (dn_read || dn_write) begin
         stall_cnt <= 0;
         if (dn_write) mem[dn_addr] <= dn_wdata;
         if (dn_read) begin
            rd_pend <= 1'b1;
            rd_addr <= dn_addr;
            lat_cnt <= rd_lat;
         end
      end
      if (rd_pend) begin
         if (lat_cnt <= 1) begin
            dn_rvalid <= 1'b1;
            dn_rdata  <= mem[rd_addr];
            rd_pend   <= 1'b0;
         end else begin
            lat_cnt <= lat_cnt - 1;
         end
      end
   end

   // ---------------- scoreboard ----------------
   logic [40:0] exp_q [$];   // {is_write, addr, data}
   logic        both_seen = 1'b0;

   task automatic chk(input logic ok, input string req,
                      input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor: a transaction is accepted at the next edge when requested and not stalled
   always @(negedge clk) begin
      if (rst_n) begin
         if (dn_read && dn_write) both_seen = 1'b1;
         if ((dn_read || dn_write) && !dn_stall) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R7 unexpected downstream transaction",
                   {23'b0, dn_write, dn_addr, dn_wdata}, 64'h0);
            end else begin
               logic [40:0] e;
               e = exp_q.pop_front();
               if (e[40])
                  chk(dn_write && dn_addr == e[39:32] && dn_wdata == e[31:0],
                      "R3 downstream write", {23'b0, dn_write, dn_addr, dn_wdata},
                      {23'b0, e});
               else
                  chk(dn_read && dn_addr == e[39:32], "R4 downstream read",
                      {55'b0, dn_read, dn_addr}, {55'b0, 1'b1, e[39:32]});
            end
         end
      end
   end

   // ---------------- host driver ----------------
   task automatic host_write(input logic [7:0] a, input logic [63:0] d);
      @(negedge clk);
      host_addr  = a[HOST_AW-1:0];
      host_wdata = d;
      host_wr    = 1'b1;
      @(negedge clk);
      host_wr    = 1'b0;
   endtask

   task automatic host_read(input logic [7:0] a, output logic [63:0] d);
      host_addr = a[HOST_AW-1:0];
      host_rd   = 1'b1;
      #1;
      d         = host_rdata;
      host_rd   = 1'b0;
   endtask

   task automatic push_wr(input logic [7:0] a, input logic [31:0] d);
      exp_q.push_back({1'b1, a, d});
   endtask

   task automatic push_rd(input logic [7:0] a);
      exp_q.push_back({1'b0, a, 32'h0});
   endtask

   task automatic wait_idle(input int limit, output int polls);
      logic [63:0] v;
      polls = 0;
      for (int k = 0; k < limit; k++) begin
         host_read(8'h10, v);
         if (v[9:8] == 2'b00) break;
         polls++;
         @(negedge clk);
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      logic [63:0] v, exp_desc;
      int polls;

      exp_desc = (64'(P_LSB) << 1) | (64'(P_XW) << 2) | (64'(P_CS) << 8) |
                 (64'(P_CPOL) << 14) | (64'(P_CPHA) << 15) |
                 (64'(P_SCLK) << 22) | (64'(P_ID) << 32);

      // R1 reset state
      repeat (3) @(negedge clk);
      host_read(8'h10, v); chk(v == 0, "R1 cmd in reset", v, 0);
      host_read(8'h18, v); chk(v == 0, "R1 result in reset", v, 0);
      host_read(8'h20, v); chk(v == 0, "R1 stage in reset", v, 0);
      chk(!dn_read && !dn_write, "R1 downstream idle", {62'b0, dn_read, dn_write}, 0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      host_read(8'h10, v); chk(v == 0, "R1 cmd after reset", v, 0);

      // R2 descriptor
      host_read(8'h08, v); chk(v == exp_desc, "R2 descriptor fields", v, exp_desc);

      // R3 write with staged data
      host_write(8'h20, 64'hFFFF_0000_DEAD_BEEF);
      host_read(8'h20, v);
      chk(v == 64'h0000_0000_DEAD_BEEF, "R3 stage readback", v, 64'hDEADBEEF);
      push_wr(8'h12, 32'hDEAD_BEEF);
      host_write(8'h10, 64'h0000_0000_0000_0112);
      wait_idle(20, polls);
      host_read(8'h10, v); chk(v == 64'h12, "R5 write bit self-clears", v, 64'h12);

      // R4 read back the written word
      push_rd(8'h12);
      host_write(8'h10, 64'h0000_0000_0000_0212);
      wait_idle(20, polls);
      host_read(8'h18, v);
      chk(v == 64'h0000_0000_DEAD_BEEF, "R4 read result", v, 64'hDEADBEEF);

      // R6 stalled write, then stalled read with latency
      stall_len = 5; rd_lat = 3;
      host_write(8'h20, 64'h1234_5678);
      push_wr(8'h34, 32'h1234_5678);
      host_write(8'h10, 64'h0000_0000_0000_0134);
      host_read(8'h10, v);
      chk(v == 64'h134, "R5 write bit set while outstanding", v, 64'h134);
      @(negedge clk); @(negedge clk);
      chk(dn_write && dn_addr == 8'h34 && dn_wdata == 32'h1234_5678,
          "R6 write held during stall", {23'b0, dn_write, dn_addr, dn_wdata},
          {23'b0, 1'b1, 8'h34, 32'h1234_5678});
      wait_idle(40, polls);
      push_rd(8'h34);
      host_write(8'h10, 64'h0000_0000_0000_0234);
      host_read(8'h10, v);
      chk(v == 64'h234, "R5 read bit set while outstanding", v, 64'h234);
      wait_idle(40, polls);
      host_read(8'h18, v);
      chk(v == 64'h1234_5678, "R4 read after stall and latency", v, 64'h12345678);

      // R7 command while busy
      stall_len = 8;
      host_write(8'h20, 64'hCAFE_0040);
      push_wr(8'h40, 32'hCAFE_0040);
      host_write(8'h10, 64'h0000_0000_0000_0140);
      host_write(8'h10, 64'h0000_0000_0000_0241);
      host_read(8'h10, v);
      chk(v == 64'h140, "R7 busy command ignored", v, 64'h140);
      wait_idle(40, polls);
      host_read(8'h10, v);
      chk(v == 64'h40, "R7 only first command ran", v, 64'h40);

      // R8 both request bits
      stall_len = 0;
      host_write(8'h10, 64'h0000_0000_0000_0350);
      host_read(8'h10, v);
      chk(v == 64'h40, "R8 dual request ignored", v, 64'h40);
      @(negedge clk); @(negedge clk);
      chk(!dn_read && !dn_write, "R8 no transaction", {62'b0, dn_read, dn_write}, 0);

      // R9 timeout with a stuck downstream side
      hang = 1'b1;
      host_write(8'h10, 64'h0000_0000_0000_0222);
      repeat (10) @(negedge clk);
      host_read(8'h10, v);
      chk(v == 64'h222, "R9 request still pending", v, 64'h222);
      wait_idle(TO_CYC + 20, polls);
      chk(polls >= 28 && polls <= 32, "R9 abort timing", 64'(polls), 64'd30);
      host_read(8'h10, v);
      chk(v == 64'h22, "R9 request bit cleared", v, 64'h22);
      host_read(8'h18, v);
      chk(v == 64'h1_1234_5678, "R9 debug flag set", v, 64'h1_12345678);
      hang = 1'b0;
      push_rd(8'h12);
      host_write(8'h10, 64'h0000_0000_0000_0212);
      wait_idle(20, polls);
      host_read(8'h18, v);
      chk(v == 64'hDEAD_BEEF, "R9 flag cleared by next command", v, 64'hDEADBEEF);

      // R10 unmapped and read-only
      host_read(8'h00, v); chk(v == 0, "R10 unmapped 0x00", v, 0);
      host_read(8'h28, v); chk(v == 0, "R10 unmapped 0x28", v, 0);
      host_write(8'h08, '1);
      host_read(8'h08, v); chk(v == exp_desc, "R10 descriptor write ignored", v, exp_desc);
      host_write(8'h18, '1);
      host_read(8'h18, v); chk(v == 64'hDEAD_BEEF, "R10 result write ignored", v, 64'hDEADBEEF);
      host_write(8'h30, '1);
      host_read(8'h30, v); chk(v == 0, "R10 unmapped write ignored", v, 0);
      host_read(8'h10, v); chk(v == 64'h12, "R10 cmd untouched", v, 64'h12);
      repeat (4) @(negedge clk);

      // R11 and scoreboard drain
      chk(!both_seen, "R11 read and write never together", {63'b0, both_seen}, 0);
      chk(exp_q.size() == 0, "R3 all expected transactions seen",
          64'(exp_q.size()), 0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule